// File: doc/BRIEF.md
# Dual-Port Synchronous RAM with Selectable Output Timing

This block is a static RAM with two fully independent access ports, left and right. Each port has its own clock and reset, a pair of select inputs, a read/write control, an address, write data and an output enable. Each port can read or write any word while the other port does the same, each on its own clock. Depth and word width are parameters.

Every input except output enable is captured on the rising edge of the owning port's clock. Each port picks its read timing at run time with its `pipe` input. In flow-through timing the read word appears in the cycle right after the edge that captures the address. In pipelined timing the word passes through one more output register. Pipelined timing also delays the effect of the select inputs on output drive by one cycle.

Output pads are modelled as a data bus plus a drive-enable flag. If both ports write the same word on the same edge, the left port's data is kept and a one-cycle collision flag is raised. This flag is timed by the left clock. The address of each port is expected to come from a burst address generator outside this block.

Top module: `dpr_ram`

## Requirements
- R1: With `pipe` low at the capturing edge, a read (rw high, port selected) shows the addressed word on `rdata` with `drive` high in the cycle right after the edge that captured the address.
- R2: With `pipe` high, the read word and `drive` appear one cycle later: after the capturing edge `drive` is still low if the port was idle before, and after the next edge `rdata` holds the word and `drive` is high.
- R3: A write (rw low) takes place only when the port is selected. A write attempted while either select input is inactive leaves the stored word unchanged.
- R4: A port is selected only when `sel_n` is low and `sel` is high. In flow-through timing an unselected port has `drive` low after the next edge, and both `drive` outputs are low during reset.
- R5: In pipelined timing a change of selection reaches `drive` one edge late. Deselecting the port keeps `drive` high for one more cycle. After reselecting, one cycle with `drive` low comes before `drive` goes high again.
- R6: Output enable `oe_n` acts without a clock. When it is high, `drive` is low at once. When it goes back low during a read, `drive` returns at once.
- R7: During a write cycle `drive` stays low even while `oe_n` is low, in both timings.
- R8: When both ports write the same address on the same edge, the left port's data is stored and `collision` is high for exactly the following cycle. Writes to different addresses do not raise it.
- R9: Both ports work at the same time. Simultaneous reads of different words return the correct word on each port, and simultaneous writes to different words both store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l | input | 1 | Left port clock |
| rst_l_n | input | 1 | Left port asynchronous reset, active low |
| sel_n_l | input | 1 | Left select, active low |
| sel_l | input | 1 | Left select, active high |
| rw_l | input | 1 | Left read (1) / write (0) |
| addr_l | input | AW | Left word address |
| wdata_l | input | DW | Left write data |
| pipe_l | input | 1 | Left timing: 0 flow-through, 1 pipelined |
| oe_n_l | input | 1 | Left output enable, active low, unclocked |
| rdata_l | output | DW | Left read data |
| drive_l | output | 1 | Left output drive enable |
| clk_r | input | 1 | Right port clock |
| rst_r_n | input | 1 | Right port asynchronous reset, active low |
| sel_n_r | input | 1 | Right select, active low |
| sel_r | input | 1 | Right select, active high |
| rw_r | input | 1 | Right read (1) / write (0) |
| addr_r | input | AW | Right word address |
| wdata_r | input | DW | Right write data |
| pipe_r | input | 1 | Right timing: 0 flow-through, 1 pipelined |
| oe_n_r | input | 1 | Right output enable, active low, unclocked |
| rdata_r | output | DW | Right read data |
| drive_r | output | 1 | Right output drive enable |
| collision | output | 1 | One-cycle flag for a same-address double write (left clock) |

## Verification
The main path is tried with a table of transfers. In each one, one port writes and the other port reads the word back. The table varies the writing side, the read timing, and addresses at both ends of the range. A wrong data path, a swapped bank or a missing latency stage shows up as a wrong word or a misplaced `drive` cycle. Directed sequences then toggle the selects during a pipelined stream to tell immediate deselection from delayed deselection. They pulse output enable without a clock, write with output enable held low, and try writes while unselected. Finally, paired writes to the same address and to different addresses separate the collision path from ordinary concurrent writes.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

   typedef enum logic {
      OUT_FLOW = 1'b0,
      OUT_PIPE = 1'b1
   } out_mode_e;

   localparam int unsigned NUM_PORTS = 2;

endpackage

// File: rtl/dpr_port.sv
module dpr_port
   import dpr_pkg::*;
#(
   parameter int unsigned DW = 8,
   parameter int unsigned AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel_n_i,
   input  logic          sel_i,
   input  logic          rw_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          pipe_i,
   input  logic          oe_n_i,
   input  logic [DW-1:0] rd_word_i,
   output logic          wr_en_o,
   output logic [AW-1:0] wr_addr_o,
   output logic [DW-1:0] wr_data_o,
   output logic [AW-1:0] rd_addr_o,
   output logic [DW-1:0] rdata_o,
   output logic          drive_o
);

   logic          picked;
   logic [AW-1:0] addr_q;
   out_mode_e     mode_q;
   logic          sel_q, rd_q, wr_q;
   logic          sel_p, rd_p, wr_p;
   logic [DW-1:0] dout_p;
   logic          vld;

   assign picked    = ~sel_n_i & sel_i;
   assign wr_en_o   = picked & ~rw_i;
   assign wr_addr_o = addr_i;
   assign wr_data_o = wdata_i;
   assign rd_addr_o = addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         mode_q <= OUT_FLOW;
         sel_q  <= 1'b0;
         rd_q   <= 1'b0;
         wr_q   <= 1'b0;
         sel_p  <= 1'b0;
         rd_p   <= 1'b0;
         wr_p   <= 1'b0;
         dout_p <= '0;
      end else begin
         addr_q <= addr_i;
         mode_q <= out_mode_e'(pipe_i);
         sel_q  <= picked;
         rd_q   <= rw_i;
         wr_q   <= picked & ~rw_i;
         sel_p  <= sel_q;
         rd_p   <= rd_q;
         wr_p   <= wr_q;
         dout_p <= rd_word_i;
      end
   end

   always_comb begin
      if (mode_q == OUT_PIPE) begin
         vld     = sel_p & rd_p;
         rdata_o = dout_p;
      end else begin
         vld     = sel_q & rd_q;
         rdata_o = rd_word_i;
      end
   end

   assign drive_o = vld & ~oe_n_i;

   // R2: pipelined data is the word seen by the array one cycle earlier
   p_pipe_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == OUT_PIPE) && $past(rst_n)) |-> (rdata_o == $past(rd_word_i)));

   // R5: a selected read keeps driving one cycle after deselection
   p_pipe_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == OUT_PIPE) && $past(rst_n) && $past(sel_q && rd_q) && !oe_n_i) |-> drive_o);

   // R5: no drive in pipelined timing unless selected one cycle before
   p_pipe_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == OUT_PIPE) && !$past(sel_q)) |-> !drive_o);

   // R4: an unselected flow-through port does not drive
   p_desel_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_q == OUT_FLOW) && !sel_q) |-> !drive_o);

   // R7: writes never drive the bus
   p_write_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (((mode_q == OUT_FLOW) && wr_q) || ((mode_q == OUT_PIPE) && wr_p)) |-> !drive_o);

endmodule

// File: rtl/dpr_core.sv
module dpr_core #(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 256,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          clk_l,
   input  logic          rst_l_n,
   input  logic          clk_r,
   input  logic          wr_l,
   input  logic [AW-1:0] wa_l,
   input  logic [DW-1:0] wd_l,
   input  logic          wr_r,
   input  logic [AW-1:0] wa_r,
   input  logic [DW-1:0] wd_r,
   input  logic [AW-1:0] ra_l,
   input  logic [AW-1:0] ra_r,
   output logic [DW-1:0] rw_l,
   output logic [DW-1:0] rw_r,
   output logic          coll_o
);

   // Each side owns one bank and one tag vector; the XOR of the tags
   // tells which bank holds the latest word.
   logic [DW-1:0]    bank_l [DEPTH];
   logic [DW-1:0]    bank_r [DEPTH];
   logic [DEPTH-1:0] tag_l;
   logic [DEPTH-1:0] tag_r;
   logic             clash;
   logic             wr_r_eff;
   logic             coll_q;

   assign clash    = wr_l & wr_r & (wa_l == wa_r);
   assign wr_r_eff = wr_r & ~clash;

   always_ff @(posedge clk_l) begin
      if (wr_l) begin
         bank_l[wa_l] <= wd_l;
         tag_l[wa_l]  <= ~tag_r[wa_l];
      end
   end

   always_ff @(posedge clk_r) begin
      if (wr_r_eff) begin
         bank_r[wa_r] <= wd_r;
         tag_r[wa_r]  <= tag_l[wa_r];
      end
   end

   always_ff @(posedge clk_l or negedge rst_l_n) begin
      if (!rst_l_n) coll_q <= 1'b0;
      else          coll_q <= clash;
   end

   assign rw_l   = (tag_l[ra_l] ^ tag_r[ra_l]) ? bank_l[ra_l] : bank_r[ra_l];
   assign rw_r   = (tag_l[ra_r] ^ tag_r[ra_r]) ? bank_l[ra_r] : bank_r[ra_r];
   assign coll_o = coll_q;

   // R8: after a collision the left data is the visible word
   p_left_wins_r8: assert property (@(posedge clk_l) disable iff (!rst_l_n)
      coll_q |-> ((tag_l[$past(wa_l)] != tag_r[$past(wa_l)]) &&
                  (bank_l[$past(wa_l)] == $past(wd_l))));

endmodule

// File: rtl/dpr_ram.sv
module dpr_ram
   import dpr_pkg::*;
#(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 256,
   localparam int unsigned AW   = $clog2(DEPTH)
) (
   input  logic          clk_l,
   input  logic          rst_l_n,
   input  logic          sel_n_l,
   input  logic          sel_l,
   input  logic          rw_l,
   input  logic [AW-1:0] addr_l,
   input  logic [DW-1:0] wdata_l,
   input  logic          pipe_l,
   input  logic          oe_n_l,
   output logic [DW-1:0] rdata_l,
   output logic          drive_l,
   input  logic          clk_r,
   input  logic          rst_r_n,
   input  logic          sel_n_r,
   input  logic          sel_r,
   input  logic          rw_r,
   input  logic [AW-1:0] addr_r,
   input  logic [DW-1:0] wdata_r,
   input  logic          pipe_r,
   input  logic          oe_n_r,
   output logic [DW-1:0] rdata_r,
   output logic          drive_r,
   output logic          collision
);

   if (DEPTH < 2 || DEPTH != (1 << AW)) begin : g_bad_depth
      $error("dpr_ram: DEPTH must be a power of two and at least 2");
   end
   if (DW < 1) begin : g_bad_width
      $error("dpr_ram: DW must be at least 1");
   end

   logic [NUM_PORTS-1:0] clk_v, rst_v, seln_v, sel_v, rw_v, pipe_v, oen_v;
   logic [AW-1:0]        addr_v  [NUM_PORTS];
   logic [DW-1:0]        wdata_v [NUM_PORTS];
   logic [NUM_PORTS-1:0] wen_v, drive_v;
   logic [AW-1:0]        wa_v    [NUM_PORTS];
   logic [DW-1:0]        wd_v    [NUM_PORTS];
   logic [AW-1:0]        ra_v    [NUM_PORTS];
   logic [DW-1:0]        word_v  [NUM_PORTS];
   logic [DW-1:0]        rdata_v [NUM_PORTS];

   assign clk_v  = {clk_r,   clk_l};
   assign rst_v  = {rst_r_n, rst_l_n};
   assign seln_v = {sel_n_r, sel_n_l};
   assign sel_v  = {sel_r,   sel_l};
   assign rw_v   = {rw_r,    rw_l};
   assign pipe_v = {pipe_r,  pipe_l};
   assign oen_v  = {oe_n_r,  oe_n_l};
   assign addr_v[0]  = addr_l;
   assign addr_v[1]  = addr_r;
   assign wdata_v[0] = wdata_l;
   assign wdata_v[1] = wdata_r;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      dpr_port #(.DW(DW), .AW(AW)) u_port (
         .clk       (clk_v[p]),
         .rst_n     (rst_v[p]),
         .sel_n_i   (seln_v[p]),
         .sel_i     (sel_v[p]),
         .rw_i      (rw_v[p]),
         .addr_i    (addr_v[p]),
         .wdata_i   (wdata_v[p]),
         .pipe_i    (pipe_v[p]),
         .oe_n_i    (oen_v[p]),
         .rd_word_i (word_v[p]),
         .wr_en_o   (wen_v[p]),
         .wr_addr_o (wa_v[p]),
         .wr_data_o (wd_v[p]),
         .rd_addr_o (ra_v[p]),
         .rdata_o   (rdata_v[p]),
         .drive_o   (drive_v[p])
      );
   end

   dpr_core #(.DW(DW), .DEPTH(DEPTH)) u_core (
      .clk_l   (clk_l),
      .rst_l_n (rst_l_n),
      .clk_r   (clk_r),
      .wr_l    (wen_v[0]),
      .wa_l    (wa_v[0]),
      .wd_l    (wd_v[0]),
      .wr_r    (wen_v[1]),
      .wa_r    (wa_v[1]),
      .wd_r    (wd_v[1]),
      .ra_l    (ra_v[0]),
      .ra_r    (ra_v[1]),
      .rw_l    (word_v[0]),
      .rw_r    (word_v[1]),
      .coll_o  (collision)
   );

   assign rdata_l = rdata_v[0];
   assign rdata_r = rdata_v[1];
   assign drive_l = drive_v[0];
   assign drive_r = drive_v[1];

endmodule

// File: tb/test_dpr_ram.sv
module test_dpr_ram;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic       sel_n_l, sel_l, rw_l, pipe_l, oe_n_l, drive_l;
   logic [7:0] addr_l, wdata_l, rdata_l;
   logic       sel_n_r, sel_r, rw_r, pipe_r, oe_n_r, drive_r;
   logic [7:0] addr_r, wdata_r, rdata_r;
   logic       collision;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   dpr_ram #(.DW(8), .DEPTH(256)) i_dpr_ram (
      .clk_l(clk), .rst_l_n(rst_n), .sel_n_l(sel_n_l), .sel_l(sel_l), .rw_l(rw_l),
      .addr_l(addr_l), .wdata_l(wdata_l), .pipe_l(pipe_l), .oe_n_l(oe_n_l),
      .rdata_l(rdata_l), .drive_l(drive_l),
      .clk_r(clk), .rst_r_n(rst_n), .sel_n_r(sel_n_r), .sel_r(sel_r), .rw_r(rw_r),
      .addr_r(addr_r), .wdata_r(wdata_r), .pipe_r(pipe_r), .oe_n_r(oe_n_r),
      .rdata_r(rdata_r), .drive_r(drive_r),
      .collision(collision)
   );

   typedef struct packed {
      logic       wr_right;
      logic       pipe;
      logic [7:0] addr;
      logic [7:0] data;
   } vec_t;

   localparam vec_t VEC [6] = '{
      '{1'b0, 1'b0, 8'h00, 8'h11},
      '{1'b0, 1'b1, 8'hFF, 8'h22},
      '{1'b1, 1'b0, 8'h10, 8'h33},
      '{1'b1, 1'b1, 8'h7F, 8'hC4},
      '{1'b0, 1'b1, 8'h80, 8'h55},
      '{1'b1, 1'b0, 8'h01, 8'hE6}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic set_l(input logic sn, input logic s, input logic rw,
                        input logic [7:0] a, input logic [7:0] d, input logic p);
      sel_n_l = sn; sel_l = s; rw_l = rw; addr_l = a; wdata_l = d; pipe_l = p;
   endtask

   task automatic set_r(input logic sn, input logic s, input logic rw,
                        input logic [7:0] a, input logic [7:0] d, input logic p);
      sel_n_r = sn; sel_r = s; rw_r = rw; addr_r = a; wdata_r = d; pipe_r = p;
   endtask

   task automatic idle_both();
      set_l(1'b1, 1'b1, 1'b1, 8'h00, 8'h00, pipe_l);
      set_r(1'b1, 1'b1, 1'b1, 8'h00, 8'h00, pipe_r);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      oe_n_l = 1'b0;
      oe_n_r = 1'b0;
      set_l(1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0);
      set_r(1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0);
      repeat (3) tick();
      check("R4 reset drive_l", drive_l, 0);
      check("R4 reset drive_r", drive_r, 0);
      check("R8 reset collision", collision, 0);
      rst_n = 1'b1;
      tick();

      // table: one side writes, the other reads back in the given timing
      for (int i = 0; i < 6; i++) begin
         if (!VEC[i].wr_right) begin
            set_l(1'b0, 1'b1, 1'b0, VEC[i].addr, VEC[i].data, 1'b0);
            tick();
            set_l(1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0);
            set_r(1'b0, 1'b1, 1'b1, VEC[i].addr, 8'h00, VEC[i].pipe);
            tick();
            if (!VEC[i].pipe) begin
               check("R1 ft drive_r", drive_r, 1);
               check("R1 ft rdata_r", rdata_r, VEC[i].data);
            end else begin
               check("R2 pipe early drive_r", drive_r, 0);
               tick();
               check("R2 pipe drive_r", drive_r, 1);
               check("R2 pipe rdata_r", rdata_r, VEC[i].data);
            end
         end else begin
            set_r(1'b0, 1'b1, 1'b0, VEC[i].addr, VEC[i].data, 1'b0);
            tick();
            set_r(1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0);
            set_l(1'b0, 1'b1, 1'b1, VEC[i].addr, 8'h00, VEC[i].pipe);
            tick();
            if (!VEC[i].pipe) begin
               check("R1 ft drive_l", drive_l, 1);
               check("R1 ft rdata_l", rdata_l, VEC[i].data);
            end else begin
               check("R2 pipe early drive_l", drive_l, 0);
               tick();
               check("R2 pipe drive_l", drive_l, 1);
               check("R2 pipe rdata_l", rdata_l, VEC[i].data);
            end
         end
         idle_both();
         tick();
      end

      // R6: output enable acts without a clock
      set_l(1'b0, 1'b1, 1'b1, 8'h10, 8'h00, 1'b0);
      tick();
      check("R6 drive before oe", drive_l, 1);
      oe_n_l = 1'b1;
      #1;
      check("R6 oe high drive", drive_l, 0);
      oe_n_l = 1'b0;
      #1;
      check("R6 oe low drive", drive_l, 1);
      check("R6 data", rdata_l, 8'h33);

      // R7: write cycles never drive, flow-through and pipelined
      set_l(1'b0, 1'b1, 1'b0, 8'h20, 8'h9A, 1'b0);
      tick();
      check("R7 ft write drive", drive_l, 0);
      set_l(1'b0, 1'b1, 1'b0, 8'h21, 8'h9B, 1'b1);
      tick();
      tick();
      check("R7 pipe write drive", drive_l, 0);
      idle_both();
      pipe_l = 1'b0;
      tick();

      // R3: unselected writes leave memory unchanged
      set_l(1'b1, 1'b1, 1'b0, 8'h10, 8'hEE, 1'b0);
      tick();
      set_l(1'b0, 1'b0, 1'b0, 8'h10, 8'hDD, 1'b0);
      tick();
      set_l(1'b1, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0);
      set_r(1'b0, 1'b1, 1'b1, 8'h10, 8'h00, 1'b0);
      tick();
      check("R3 deselected write ignored", rdata_r, 8'h33);

      // R4: one inactive select stops drive in flow-through
      set_r(1'b0, 1'b0, 1'b1, 8'h10, 8'h00, 1'b0);
      tick();
      check("R4 sel low no drive", drive_r, 0);
      set_r(1'b1, 1'b1, 1'b1, 8'h10, 8'h00, 1'b0);
      tick();
      check("R4 sel_n high no drive", drive_r, 0);

      // R5: pipelined selection changes reach drive one edge late
      set_l(1'b0, 1'b1, 1'b1, 8'h7F, 8'h00, 1'b1);
      tick();
      tick();
      check("R5 stream drive", drive_l, 1);
      check("R5 stream data", rdata_l, 8'hC4);
      set_l(1'b1, 1'b1, 1'b1, 8'h7F, 8'h00, 1'b1);
      tick();
      check("R5 drive held after deselect", drive_l, 1);
      tick();
      check("R5 drive off", drive_l, 0);
      set_l(1'b0, 1'b1, 1'b1, 8'h7F, 8'h00, 1'b1);
      tick();
      check("R5 reselect gap", drive_l, 0);
      tick();
      check("R5 reselect drive", drive_l, 1);
      idle_both();
      pipe_l = 1'b0;
      tick();

      // R8: same-address collision, left data kept, one-cycle flag
      set_l(1'b0, 1'b1, 1'b0, 8'h40, 8'h5A, 1'b0);
      set_r(1'b0, 1'b1, 1'b0, 8'h40, 8'hA5, 1'b0);
      tick();
      check("R8 collision raised", collision, 1);
      idle_both();
      tick();
      check("R8 collision one cycle", collision, 0);
      set_r(1'b0, 1'b1, 1'b1, 8'h40, 8'h00, 1'b0);
      tick();
      check("R8 left data stored", rdata_r, 8'h5A);

      // R9: concurrent writes to different words, then concurrent reads
      set_l(1'b0, 1'b1, 1'b0, 8'h50, 8'h0F, 1'b0);
      set_r(1'b0, 1'b1, 1'b0, 8'h51, 8'hF0, 1'b0);
      tick();
      check("R8 no collision different addr", collision, 0);
      set_l(1'b0, 1'b1, 1'b1, 8'h51, 8'h00, 1'b0);
      set_r(1'b0, 1'b1, 1'b1, 8'h50, 8'h00, 1'b0);
      tick();
      check("R9 left reads right word", rdata_l, 8'hF0);
      check("R9 right reads left word", rdata_r, 8'h0F);
      check("R9 both drive", {drive_l, drive_r}, 2'b11);

      idle_both();
      tick();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule